// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two words, P and Q, and drives two decoded verdict lines: one that is high when P is greater and one that is high when P is less. A mode input chooses at run time between an unsigned comparison and a two's-complement signed one. Q is used directly. P first passes through a hold stage. While the load enable is high, the hold stage passes P straight through and also loads P into a register on each rising clock edge. While the enable is low, the stage presents the register contents, and an asynchronous active-low reset clears that register to zero.

A pair of cascade inputs takes the verdict of a less significant slice. These inputs decide the outputs only when the two words are equal. To compare a wider word, wire the two outputs of the lower slice to the cascade inputs of the next higher slice. The hold stage runs as a two-state machine with the states TRACK and HOLD. It is in TRACK whenever the enable is high and in HOLD whenever the enable is low. TRACK selects the live input and loads the register. HOLD selects the register and leaves it unchanged.

Top module: `cascade_cmp`

## Requirements
- R1: With `mode_unsigned` high, P and Q are compared as unsigned binary values (for example, 0x80 is greater than 0x7F).
- R2: With `mode_unsigned` low, P and Q are compared as two's-complement values (for example, 0x80 is less than 0x7F and 0xFF is less than 0x01).
- R3: When P is greater than Q under the selected mode, `p_gt_out` is 1 and `p_lt_out` is 0, whatever the cascade inputs are.
- R4: When P is less than Q under the selected mode, `p_gt_out` is 0 and `p_lt_out` is 1, whatever the cascade inputs are.
- R5: When P equals Q, `p_gt_out` equals `casc_gt_in` and `p_lt_out` equals `casc_lt_in`, for all four input combinations including 11.
- R6: While `p_load` is high, the P operand used in the comparison is the present value of `p_word`, with no clock delay.
- R7: While `p_load` is low, the P operand is the value `p_word` had at the last rising clock edge at which `p_load` was high, and changes on `p_word` have no effect on the outputs.
- R8: Asserting `rst_n` low clears the stored P operand to zero, so with `p_load` low after reset, P compares as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the P hold register |
| rst_n | input | 1 | Asynchronous active-low clear of the stored P |
| p_load | input | 1 | 1 = pass and load P (TRACK), 0 = use stored P (HOLD) |
| mode_unsigned | input | 1 | 1 = unsigned comparison, 0 = two's-complement comparison |
| p_word | input | WIDTH | P operand input |
| q_word | input | WIDTH | Q operand input |
| casc_gt_in | input | 1 | Greater verdict from the less significant slice |
| casc_lt_in | input | 1 | Less verdict from the less significant slice |
| p_gt_out | output | 1 | High when P is greater, or copies casc_gt_in when P equals Q |
| p_lt_out | output | 1 | High when P is less, or copies casc_lt_in when P equals Q |

## Verification
The only internal state is the stored P word. A wrong value there stays hidden until `p_load` is low. It then shows in the same cycle as a wrong verdict, either when Q is chosen close to the stored value or when P and Q should be equal and the cascade inputs fail to pass through. For this reason the bench loads a known P, drops the enable, moves `p_word` freely and probes with Q values equal to, one below and one above the held word. It also compares a behavioural model against the outputs on every clock, so a fault appears at the first cycle it affects.

// File: rtl/cascade_cmp_pkg.sv
package cascade_cmp_pkg;

    // Operating state of the P operand hold stage
    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } hold_state_e;

endpackage

// File: rtl/cmp_operand_hold.sv
module cmp_operand_hold
    import cascade_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] eff_out
);

    hold_state_e      state_d;
    logic [WIDTH-1:0] store_q;

    // State decode: TRACK while the enable is high, HOLD otherwise
    always_comb begin
        state_d = load_en ? ST_TRACK : ST_HOLD;
    end

    // Register holding the last P sampled in TRACK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (state_d == ST_TRACK) begin
            store_q <= d_in;
        end
    end

    // Output select: the live input in TRACK, the stored word in HOLD
    always_comb begin
        unique case (state_d)
            ST_TRACK: eff_out = d_in;
            ST_HOLD:  eff_out = store_q;
            default:  eff_out = store_q;
        endcase
    end

endmodule

// File: rtl/cmp_order_map.sv
module cmp_order_map #(
    parameter int WIDTH = 8
) (
    input  logic             mode_unsigned,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out
);

    localparam int MSB = WIDTH - 1;

    // In signed mode, flipping the sign bit of both operands turns
    // two's-complement order into plain unsigned order.
    logic flip;
    assign flip = ~mode_unsigned;

    generate
        if (WIDTH > 1) begin : g_wide
            assign a_out = {a_in[MSB] ^ flip, a_in[MSB-1:0]};
            assign b_out = {b_in[MSB] ^ flip, b_in[MSB-1:0]};
        end else begin : g_single
            assign a_out = a_in ^ flip;
            assign b_out = b_in ^ flip;
        end
    endgenerate

endmodule

// File: rtl/cmp_mag_chain.sv
module cmp_mag_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             seed_gt,
    input  logic             seed_lt,
    output logic             res_gt,
    output logic             res_lt
);

    // Verdict ripples from the LSB upward. A bit position where the two
    // operands differ overrides everything below it. With no differing
    // bit, the seed (the cascade inputs) arrives at the top unchanged.
    logic [WIDTH:0] gt_c;
    logic [WIDTH:0] lt_c;

    assign gt_c[0] = seed_gt;
    assign lt_c[0] = seed_lt;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic same;
            assign same        = ~(a_in[i] ^ b_in[i]);
            assign gt_c[i + 1] = (a_in[i] & ~b_in[i]) | (same & gt_c[i]);
            assign lt_c[i + 1] = (~a_in[i] & b_in[i]) | (same & lt_c[i]);
        end
    endgenerate

    assign res_gt = gt_c[WIDTH];
    assign res_lt = lt_c[WIDTH];

endmodule

// File: rtl/cascade_cmp.sv
module cascade_cmp #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_load,
    input  logic             mode_unsigned,
    input  logic [WIDTH-1:0] p_word,
    input  logic [WIDTH-1:0] q_word,
    input  logic             casc_gt_in,
    input  logic             casc_lt_in,
    output logic             p_gt_out,
    output logic             p_lt_out
);

    logic [WIDTH-1:0] p_eff;
    logic [WIDTH-1:0] p_ord;
    logic [WIDTH-1:0] q_ord;

    // R6 R7 R8: transparent hold stage with reset clear
    cmp_operand_hold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (p_load),
        .d_in    (p_word),
        .eff_out (p_eff)
    );

    // R1 R2: map the selected ordering onto unsigned order
    cmp_order_map #(.WIDTH(WIDTH)) u_map (
        .mode_unsigned (mode_unsigned),
        .a_in          (p_eff),
        .b_in          (q_word),
        .a_out         (p_ord),
        .b_out         (q_ord)
    );

    // R3 R4 R5: MSB-dominant chain seeded by the cascade inputs
    cmp_mag_chain #(.WIDTH(WIDTH)) u_chain (
        .a_in    (p_ord),
        .b_in    (q_ord),
        .seed_gt (casc_gt_in),
        .seed_lt (casc_lt_in),
        .res_gt  (p_gt_out),
        .res_lt  (p_lt_out)
    );

endmodule

// File: rtl/cascade_cmp_checker.sv
module cascade_cmp_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             p_load,
    input logic             mode_unsigned,
    input logic [WIDTH-1:0] p_word,
    input logic [WIDTH-1:0] q_word,
    input logic             casc_gt_in,
    input logic             casc_lt_in,
    input logic             p_gt_out,
    input logic             p_lt_out
);

    assert_unsigned_greater_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_load && mode_unsigned && (p_word > q_word)) |-> (p_gt_out && !p_lt_out));

    assert_signed_less_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_load && !mode_unsigned && ($signed(p_word) < $signed(q_word))) |-> (!p_gt_out && p_lt_out));

    // R3 R4: without both cascade inputs high, never both verdicts high
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(casc_gt_in && casc_lt_in) |-> !(p_gt_out && p_lt_out));

    assert_equal_passes_cascade_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_load && (p_word == q_word)) |-> (p_gt_out == casc_gt_in && p_lt_out == casc_lt_in));

    assert_hold_ignores_p_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_load && $past(!p_load) && $stable(q_word) && $stable(mode_unsigned)
         && $stable(casc_gt_in) && $stable(casc_lt_in))
        |-> ($stable(p_gt_out) && $stable(p_lt_out)));

endmodule

bind cascade_cmp cascade_cmp_checker #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .p_load        (p_load),
    .mode_unsigned (mode_unsigned),
    .p_word        (p_word),
    .q_word        (q_word),
    .casc_gt_in    (casc_gt_in),
    .casc_lt_in    (casc_lt_in),
    .p_gt_out      (p_gt_out),
    .p_lt_out      (p_lt_out)
);

// File: tb/cascade_cmp_bench.sv
`timescale 1ns/1ps
module cascade_cmp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       p_load = 1'b0;
    logic       mode_unsigned = 1'b1;
    logic [7:0] p_word = 8'h00;
    logic [7:0] q_word = 8'h00;
    logic       casc_gt_in = 1'b0;
    logic       casc_lt_in = 1'b0;
    logic       p_gt_out;
    logic       p_lt_out;

    int n_checks = 0;
    int n_fails  = 0;
    int held_p   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cascade_cmp #(.WIDTH(8)) u_cascade_cmp (
        .clk           (clk),
        .rst_n         (rst_n),
        .p_load        (p_load),
        .mode_unsigned (mode_unsigned),
        .p_word        (p_word),
        .q_word        (q_word),
        .casc_gt_in    (casc_gt_in),
        .casc_lt_in    (casc_lt_in),
        .p_gt_out      (p_gt_out),
        .p_lt_out      (p_lt_out)
    );

    // Behavioural model of the stored P word
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_p = 0;
        else if (p_load) held_p = int'(p_word);
    end

    function automatic int as_value(input int raw, input bit uns);
        if (!uns && raw >= 128) return raw - 256;
        return raw;
    endfunction

    // Compare the outputs with the model at the current time
    task automatic check(input string tag);
        int pv, qv;
        bit eg, el;
        pv = as_value(p_load ? int'(p_word) : held_p, mode_unsigned);
        qv = as_value(int'(q_word), mode_unsigned);
        if (pv > qv)      begin eg = 1'b1; el = 1'b0; end
        else if (pv < qv) begin eg = 1'b0; el = 1'b1; end
        else              begin eg = casc_gt_in; el = casc_lt_in; end
        n_checks++;
        if (p_gt_out !== eg || p_lt_out !== el) begin
            n_fails++;
            $display("FAIL %s: gt/lt actual %b%b expected %b%b (p=%h q=%h load=%b uns=%b)",
                     tag, p_gt_out, p_lt_out, eg, el, p_word, q_word, p_load, mode_unsigned);
        end
    endtask

    // Apply one input set after a rising edge, check at the falling edge
    task automatic step(input bit ld, input bit uns, input logic [7:0] p,
                        input logic [7:0] q, input bit cg, input bit cl, input string tag);
        @(posedge clk);
        #4;
        p_load = ld; mode_unsigned = uns; p_word = p; q_word = q;
        casc_gt_in = cg; casc_lt_in = cl;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #5000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R8: reset clears the store; P reads as 0 with load low
        p_word = 8'hA5;
        repeat (2) @(posedge clk);
        #4 rst_n = 1'b1;
        step(0, 1, 8'h5A, 8'h00, 0, 1, "R8");
        step(0, 1, 8'hC3, 8'h01, 1, 0, "R8");

        // R1 / R2: the same operands ordered differently per mode
        step(1, 1, 8'h80, 8'h7F, 0, 0, "R1");
        step(1, 0, 8'h80, 8'h7F, 0, 0, "R2");
        step(1, 1, 8'hFF, 8'h01, 0, 1, "R1");
        step(1, 0, 8'hFF, 8'h01, 1, 0, "R2");
        step(1, 0, 8'hFE, 8'hFF, 0, 0, "R2");

        // R3 / R4: strict verdicts override every cascade combination
        for (int c = 0; c < 4; c++) begin
            step(1, 1, 8'h41, 8'h40, c[1], c[0], "R3");
            step(1, 0, 8'h01, 8'h02, c[1], c[0], "R4");
        end

        // R5: equality passes all four cascade pairs in both modes
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                step(1, m[0], 8'h9C, 8'h9C, c[1], c[0], "R5");

        // R6: transparent path follows p_word with no delay
        step(1, 1, 8'h10, 8'h20, 0, 0, "R6");
        step(1, 1, 8'h30, 8'h20, 0, 0, "R6");

        // R7: load 0x40, then hold while p_word moves
        step(1, 1, 8'h40, 8'h00, 0, 0, "R7");
        step(0, 1, 8'hFF, 8'h40, 1, 1, "R7");
        step(0, 1, 8'h00, 8'h3F, 0, 0, "R7");
        step(0, 1, 8'h7E, 8'h41, 0, 0, "R7");
        step(0, 0, 8'hC0, 8'h40, 0, 1, "R7");
        step(0, 0, 8'h12, 8'hC0, 0, 0, "R7");

        // Broad sweep across both modes, load toggling
        for (int k = 0; k < 400; k++) begin
            step(k % 5 != 0, k[1], 8'((k * 37) ^ (k >> 2)), 8'((k * 53) + 7),
                 k[2], k[3], "R1");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule